// File: doc/BRIEF.md
# TDM Frame Sync Checker

This block watches a received frame-sync line on a time-division multiplexed serial link and tells whether the sync pulses arrive once per frame, at the position the configuration predicts. The bit-clock logic upstream hands it a one-cycle strobe per bit time and the already-synchronized sync line. The checker samples the line a programmable number of fast-clock cycles after each strobe, so the sample lands in a settled part of the bit. The first leading edge of an asserted sync after enable fixes the frame phase. From then on a free-running bit counter walks the frame, and each frame is judged at its last bit.

Three results come out. The first is a sticky status that says whether the most recent complete frame was clean. The other two are one-cycle event pulses: one for a frame whose expected sync was absent, and one for a frame that carried a sync edge anywhere else. The status is meant for bring-up. The events are meant for spotting a loss of alignment in service. All pins are plain control and status levels or strobes. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `fsync_checker`

## Requirements
- R1: A frame lasts L = 8 × `cfg_slots` + `cfg_xbit` bit times, where `cfg_slots` is 10 bits wide. Once locked, the bit counter wraps after L sampling points, and the last of them (position L−1) closes the frame.
- R2: With `cfg_pol` = 0 the sync is asserted when `fsync_in` is 1. With `cfg_pol` = 1 it is asserted when `fsync_in` is 0.
- R3: `fsync_in` is sampled exactly `cfg_dly` clock cycles after the cycle in which `bit_stb` is 1, with 0 meaning the strobe cycle itself. Values outside that cycle have no effect. `cfg_dly` must be shorter than the bit period.
- R4: A sync edge is a sample that is asserted when the previous sample was not. The first sync edge after enable locks the frame phase, and that sample takes the expected position.
- R5: The expected position is E = (L − ⌊`cfg_loc`/2⌋) mod L. `cfg_loc` counts half bit times before bit 0 of slot 0 and is rounded down to whole bit times. It must be less than 2L.
- R6: At each frame close, `sync_good` is set to 1 if the frame had a sync edge at E and no sync edge elsewhere, and to 0 otherwise. It holds its value between frame closes.
- R7: `ev_missing` pulses for one cycle, in the cycle after a frame close, when that frame had no sync edge at E.
- R8: `ev_extra` pulses for one cycle, in the cycle after a frame close, when that frame had a sync edge at any position other than E. Both events may pulse together.
- R9: Before lock, no `ev_missing` pulse is produced, however long the line stays idle.
- R10: While `cfg_en` is 0, all outputs are 0 from the next cycle on, the lock is dropped, and the sync line is ignored.
- R11: After reset, `sync_good`, `ev_extra` and `ev_missing` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Checker enable |
| cfg_pol | input | 1 | Sync polarity, 1 = active low |
| cfg_slots | input | 10 | Number of 8-bit slots per frame |
| cfg_xbit | input | 1 | Adds one frame bit per frame |
| cfg_loc | input | 5 | Sync lead before slot 0 bit 0, in half bit times |
| cfg_dly | input | 16 | Clock cycles from bit strobe to sync sample |
| bit_stb | input | 1 | One-cycle strobe at the start of each bit time |
| fsync_in | input | 1 | Synchronized frame-sync line |
| sync_good | output | 1 | Sticky status: the last frame was clean |
| ev_extra | output | 1 | One-cycle pulse: a stray sync edge was seen in the last frame |
| ev_missing | output | 1 | One-cycle pulse: the expected sync was absent in the last frame |

## Verification
The main sequence is tried on five configurations. Each varies the frame length, the frame bit, the sync lead and the polarity, and each is followed by one of four frame patterns: a clean frame, a frame with no sync, a frame with an added stray sync, and a frame with the sync moved one bit early. The four patterns separate the outcomes "good", "missing only", "extra only" and "both". A clean frame then follows each bad one, which shows that the status recovers. Directed runs drive the sync line only outside, or only inside, the delayed sampling cycle to pin down the sample timing. They also toggle the enable to show that the sync line is ignored and that an idle line before lock raises no event.

// File: rtl/fsync_pkg.sv
package fsync_pkg;
  localparam int SLOT_W = 10;
  localparam int LOC_W  = 5;
  localparam int DLY_W  = 16;
  localparam int POS_W  = SLOT_W + 4;
endpackage

// File: rtl/fs_sample_timer.sv
module fs_sample_timer #(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             bit_stb,
  input  logic [DLY_W-1:0] dly,
  output logic             samp
);
  logic             pend;
  logic [DLY_W-1:0] dcnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      pend <= 1'b0;
      dcnt <= '0;
    end else if (bit_stb) begin
      pend <= (dly != '0);
      dcnt <= dly - 1'b1;
    end else if (pend) begin
      if (dcnt == '0) pend <= 1'b0;
      else            dcnt <= dcnt - 1'b1;
    end
  end

  always_comb begin
    if (bit_stb) samp = en && (dly == '0);
    else         samp = en && pend && (dcnt == '0);
  end

  // R3: a sample is never taken when the previous cycle already took one, for any delay of at least 1
  assert_single_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (samp && !bit_stb) |-> !$past(samp) || $past(bit_stb));
endmodule

// File: rtl/fs_phase_ctr.sv
module fs_phase_ctr #(
  parameter int SLOT_W = 10,
  parameter int LOC_W  = 5,
  parameter int POS_W  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              samp,
  input  logic              lead,
  input  logic [SLOT_W-1:0] slots,
  input  logic              xbit,
  input  logic [LOC_W-1:0]  loc,
  output logic              locked,
  output logic              act,
  output logic              at_exp,
  output logic              frm_end
);
  logic [POS_W-1:0] len, off, exp_pos, pos, cnt;

  always_comb begin
    len     = POS_W'({slots, 3'b000}) + POS_W'(xbit);
    off     = POS_W'(loc >> 1);
    exp_pos = (off == '0) ? '0 : len - off;
    pos     = locked ? cnt : exp_pos;
    act     = samp && (locked || lead);
    at_exp  = (pos == exp_pos);
    frm_end = (pos == len - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      locked <= 1'b0;
      cnt    <= '0;
    end else if (act) begin
      locked <= 1'b1;
      cnt    <= frm_end ? '0 : pos + 1'b1;
    end
  end

  // R1: once locked, the bit counter stays inside the frame
  assert_pos_in_frame_R1: assert property (@(posedge clk) disable iff (!rst_n || !en)
    locked |-> cnt < len);
  // R4: the lock takes hold only on a sampled sync edge
  assert_lock_on_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(samp && lead));
endmodule

// File: rtl/fs_judge.sv
module fs_judge (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic act,
  input  logic lead,
  input  logic at_exp,
  input  logic frm_end,
  output logic sync_good,
  output logic ev_missing,
  output logic ev_extra
);
  logic hit_q, stray_q, hit_n, stray_n;

  always_comb begin
    hit_n   = hit_q   || (lead && at_exp);
    stray_n = stray_q || (lead && !at_exp);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      hit_q      <= 1'b0;
      stray_q    <= 1'b0;
      sync_good  <= 1'b0;
      ev_missing <= 1'b0;
      ev_extra   <= 1'b0;
    end else begin
      ev_missing <= 1'b0;
      ev_extra   <= 1'b0;
      if (act) begin
        if (frm_end) begin
          sync_good  <= hit_n && !stray_n;
          ev_missing <= !hit_n;
          ev_extra   <= stray_n;
          hit_q      <= 1'b0;
          stray_q    <= 1'b0;
        end else begin
          hit_q   <= hit_n;
          stray_q <= stray_n;
        end
      end
    end
  end

  // R7: a missing-sync pulse only follows a frame close
  assert_miss_at_close_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_missing |-> $past(act && frm_end));
  // R8: an extra-sync pulse only follows a frame close
  assert_extra_at_close_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_extra |-> $past(act && frm_end));
  // R6: the status changes only at a frame close
  assert_good_frame_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(act && frm_end) && $past(en)) |-> $stable(sync_good));
  // R10: disabling clears every output
  assert_disable_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!sync_good && !ev_missing && !ev_extra));
endmodule

// File: rtl/fsync_checker.sv
module fsync_checker
  import fsync_pkg::*;
#(
  parameter int P_SLOT_W = SLOT_W,
  parameter int P_LOC_W  = LOC_W,
  parameter int P_DLY_W  = DLY_W,
  localparam int P_POS_W = P_SLOT_W + 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_en,
  input  logic                cfg_pol,
  input  logic [P_SLOT_W-1:0] cfg_slots,
  input  logic                cfg_xbit,
  input  logic [P_LOC_W-1:0]  cfg_loc,
  input  logic [P_DLY_W-1:0]  cfg_dly,
  input  logic                bit_stb,
  input  logic                fsync_in,
  output logic                sync_good,
  output logic                ev_extra,
  output logic                ev_missing
);
  logic samp, asserted, prev_q, lead;
  logic locked, act, at_exp, frm_end;

  fs_sample_timer #(.DLY_W(P_DLY_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .en(cfg_en), .bit_stb(bit_stb),
    .dly(cfg_dly), .samp(samp)
  );

  assign asserted = fsync_in ^ cfg_pol;
  assign lead     = samp && asserted && !prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !cfg_en) prev_q <= 1'b0;
    else if (samp)         prev_q <= asserted;
  end

  fs_phase_ctr #(.SLOT_W(P_SLOT_W), .LOC_W(P_LOC_W), .POS_W(P_POS_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .en(cfg_en), .samp(samp), .lead(lead),
    .slots(cfg_slots), .xbit(cfg_xbit), .loc(cfg_loc),
    .locked(locked), .act(act), .at_exp(at_exp), .frm_end(frm_end)
  );

  fs_judge u_judge (
    .clk(clk), .rst_n(rst_n), .en(cfg_en), .act(act), .lead(lead),
    .at_exp(at_exp), .frm_end(frm_end), .sync_good(sync_good),
    .ev_missing(ev_missing), .ev_extra(ev_extra)
  );

  // R9: no missing-sync event unless the phase was already locked
  assert_no_miss_unlocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_missing |-> $past(locked));
endmodule

// File: tb/fsync_checker_tb.sv
module fsync_checker_tb;
  localparam int BITP = 6;
  localparam int DLY  = 2;
  localparam int NV   = 5;
  // {slots[10], xbit, loc[5], pol, kind[2], exp_good, exp_miss, exp_extra}
  // kind: 0 clean, 1 no sync, 2 added stray sync, 3 sync one bit early
  localparam logic [21:0] VEC [NV] = '{
    {10'd2, 1'b0, 5'd0,  1'b0, 2'd0, 3'b100},
    {10'd2, 1'b1, 5'd4,  1'b1, 2'd1, 3'b010},
    {10'd3, 1'b0, 5'd5,  1'b0, 2'd2, 3'b001},
    {10'd1, 1'b1, 5'd2,  1'b1, 2'd3, 3'b011},
    {10'd4, 1'b0, 5'd31, 1'b0, 2'd0, 3'b100}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_en = 1'b0, cfg_pol = 1'b0, cfg_xbit = 1'b0;
  logic [9:0] cfg_slots = '0;
  logic [4:0] cfg_loc = '0;
  logic [15:0] cfg_dly = 16'(DLY);
  logic bit_stb = 1'b0, fsync_in = 1'b0;
  logic sync_good, ev_extra, ev_missing;
  int checks = 0, errs = 0;
  int mcnt = 0, xcnt = 0;

  always #2 clk = ~clk;

  fsync_checker u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_pol(cfg_pol),
    .cfg_slots(cfg_slots), .cfg_xbit(cfg_xbit), .cfg_loc(cfg_loc),
    .cfg_dly(cfg_dly), .bit_stb(bit_stb), .fsync_in(fsync_in),
    .sync_good(sync_good), .ev_extra(ev_extra), .ev_missing(ev_missing)
  );

  always @(posedge clk) begin
    if (ev_missing) mcnt <= mcnt + 1;
    if (ev_extra)   xcnt <= xcnt + 1;
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // mode 0: level held for the whole bit, 1: only in the sample cycle, 2: all but the sample cycle
  task automatic run_bit(input logic a, input int mode);
    for (int k = 0; k < BITP; k++) begin
      logic lvl;
      lvl = a && (mode == 0 || (mode == 1 && k == DLY) || (mode == 2 && k != DLY));
      bit_stb  = (k == 0);
      fsync_in = lvl ^ cfg_pol;
      @(negedge clk);
    end
    bit_stb = 1'b0;
  endtask

  task automatic configure(input logic [9:0] s, input logic x, input logic [4:0] l, input logic p);
    cfg_en = 1'b0;
    cfg_slots = s; cfg_xbit = x; cfg_loc = l; cfg_pol = p;
    fsync_in = p;
    repeat (3) @(negedge clk);
    cfg_en = 1'b1;
    @(negedge clk);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    int len, e, m0, x0;
    @(negedge clk);
    repeat (3) @(negedge clk);
    check("R11 reset good", int'(sync_good), 0);
    check("R11 reset missing", int'(ev_missing), 0);
    check("R11 reset extra", int'(ev_extra), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [1:0] kind;
      int xp, sp;
      kind = VEC[v][4:3];
      configure(VEC[v][21:12], VEC[v][11], VEC[v][10:6], VEC[v][5]);
      len = 8 * int'(VEC[v][21:12]) + int'(VEC[v][11]);
      e   = (int'(VEC[v][10:6]) / 2 == 0) ? 0 : len - int'(VEC[v][10:6]) / 2;
      xp  = (e + 3) % len;
      sp  = (e + len - 1) % len;
      m0 = mcnt; x0 = xcnt;
      for (int b = 0; b < 3; b++) run_bit(1'b0, 0);
      check("R9 idle before lock", mcnt - m0, 0);
      run_bit(1'b1, 0);
      for (int b = e + 1; b < len; b++) run_bit(1'b0, 0);
      check("R4 R2 R5 lock frame good", int'(sync_good), 1);
      check("R4 lock frame no events", (mcnt - m0) + (xcnt - x0), 0);
      m0 = mcnt; x0 = xcnt;
      for (int b = 0; b < len; b++) begin
        logic a;
        a = ((kind == 2'd0 || kind == 2'd2) && b == e) ||
            (kind == 2'd2 && b == xp) || (kind == 2'd3 && b == sp);
        run_bit(a, 0);
      end
      check("R6 R1 pattern good", int'(sync_good), int'(VEC[v][2]));
      check("R7 pattern missing", mcnt - m0, int'(VEC[v][1]));
      check("R8 pattern extra", xcnt - x0, int'(VEC[v][0]));
      m0 = mcnt; x0 = xcnt;
      for (int b = 0; b < len; b++) run_bit(b == e, 0);
      check("R6 recovery good", int'(sync_good), 1);
      check("R7 R8 recovery no events", (mcnt - m0) + (xcnt - x0), 0);
    end

    // Directed: sampling instant (L=16, E=0)
    configure(10'd2, 1'b0, 5'd0, 1'b0);
    run_bit(1'b0, 0);
    run_bit(1'b1, 0);
    for (int b = 1; b < 16; b++) run_bit(1'b0, 0);
    m0 = mcnt;
    run_bit(1'b1, 2);
    for (int b = 1; b < 16; b++) run_bit(1'b0, 0);
    check("R3 sync outside sample cycle ignored", mcnt - m0, 1);
    check("R3 outside sample good", int'(sync_good), 0);
    m0 = mcnt; x0 = xcnt;
    run_bit(1'b1, 1);
    for (int b = 1; b < 16; b++) run_bit(1'b0, 0);
    check("R3 sync in sample cycle good", int'(sync_good), 1);
    check("R3 sample cycle no events", (mcnt - m0) + (xcnt - x0), 0);

    // Directed: disable
    cfg_en = 1'b0;
    @(negedge clk);
    check("R10 disable clears good", int'(sync_good), 0);
    m0 = mcnt; x0 = xcnt;
    for (int b = 0; b < 40; b++) run_bit(b % 5 == 0, 0);
    check("R10 disabled no events", (mcnt - m0) + (xcnt - x0), 0);
    check("R10 disabled good", int'(sync_good), 0);
    cfg_en = 1'b1;
    @(negedge clk);
    m0 = mcnt;
    for (int b = 0; b < 40; b++) run_bit(1'b0, 0);
    check("R9 long idle after enable", mcnt - m0, 0);
    check("R9 long idle good", int'(sync_good), 0);
    summary();
  end
endmodule